// File: doc/BRIEF.md
# Multi-Format Serial Audio Port

This block links a pair of parallel PCM sample registers to a bit-serial audio line in slave mode. An external bit clock and frame clock arrive as inputs and are oversampled by the system clock. One position counter, restarted at every frame boundary, drives both directions. The transmit side places a left/right sample pair into one selected slot pair. The receive side collects a left/right pair from a slot pair selected on its own.

Every framing choice is a static configuration input: two-channel I2S, left-justified or right-justified, four- or eight-slot TDM, a 50% or single-pulse frame clock, the frame length in bit clocks, the word length, the data delay and the polarity of both clocks. The line driver is expressed as a data bit plus an output enable, so the pad can release the line in slots that belong to other devices.

Top module: `sap_port`

## Requirements
- R1: While `rstN` is low, `sdOe`, `sdOut` and `rxValid` are 0 and `rxLeft`/`rxRight` are zero.
- R2: Format code 0 (I2S), with a 50% frame clock: a frame starts at the falling edge of the polarity-corrected frame clock. Each channel slot is half a frame. The left word's MSB sits one bit clock after the frame start, and the right word's MSB sits one bit clock after the half-frame point.
- R3: Format code 1 (left-justified): a frame starts at the rising edge of the frame clock, and each word's MSB is in the first bit clock of its half-frame.
- R4: Format code 2 (right-justified): the MSB lies `slotWidth - wordBits` bit clocks into each half-frame, so the LSB is the last bit of the half.
- R5: Word-length code 0/1/2/3 selects 24/20/18/16 bits. Transmit sends the low `wordBits` bits of each sample, MSB first. Received words are sign-extended to the full sample width.
- R6: Format code 3 (TDM) divides the frame into 4 slots (`tdmWide`=0) or 8 slots (`tdmWide`=1) of equal width. Delay code 0/1/2 places the MSB 0/1/8 bit clocks after the slot start.
- R7: In TDM the transmit pair and the receive pair are chosen independently. Pair p occupies slots 2p and 2p+1, left first. With four slots only bit 0 of the pair select counts.
- R8: `sdOe` is 1 exactly during the bit clocks of the slots the transmit pair owns. `sdOut` carries a sample bit inside a word window and 0 in every other bit clock.
- R9: With `pulseSync`=1, the rising edge of a one-bit-clock frame pulse marks the frame start, whatever the format.
- R10: With `bclkInv`=1 the line is sampled on falling bit-clock edges and driven on rising edges. `lrclkInv`=1 inverts the frame clock before any edge test.
- R11: `rxValid` is a one-cycle pulse raised once per frame after the last bit of the right word. `rxLeft`/`rxRight` change only in that cycle.
- R12: Frame-length code 0/1/2/3/4 gives 32/48/64/128/256 bit clocks per frame, and codes 5 to 7 give 64.
- R13: The transmit sample pair is captured at the frame start. Input changes after the start reach the line only in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial clocks |
| rstN | input | 1 | Active-low synchronous reset |
| bclkIn | input | 1 | Serial bit clock |
| lrclkIn | input | 1 | Serial frame clock |
| sdIn | input | 1 | Serial receive data |
| fmtSel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 TDM |
| tdmWide | input | 1 | TDM slot count: 0 four, 1 eight |
| pulseSync | input | 1 | Frame clock is a single pulse |
| frameCode | input | 3 | Bit clocks per frame (R12) |
| delayCode | input | 2 | TDM data delay: 0, 1 or 8 bit clocks |
| wordCode | input | 2 | Word length (R5) |
| bclkInv | input | 1 | Bit clock polarity |
| lrclkInv | input | 1 | Frame clock polarity |
| txPairSel | input | 2 | TDM slot pair for transmit |
| rxPairSel | input | 2 | TDM slot pair for receive |
| txLeft | input | SAMPLE_W | Left sample to transmit |
| txRight | input | SAMPLE_W | Right sample to transmit |
| sdOut | output | 1 | Serial transmit data |
| sdOe | output | 1 | Transmit line enable |
| rxLeft | output | SAMPLE_W | Last received left word, sign-extended |
| rxRight | output | SAMPLE_W | Last received right word, sign-extended |
| rxValid | output | 1 | New receive pair strobe |

## Verification
The bench keeps the defaults `SAMPLE_W`=24 and `SYNC_STAGES`=2 and runs the bit clock at one eighth of the system clock. That leaves enough oversampling margin to check the line in every bit clock, including the 256-clock eight-slot frames with eight-clock delay and the top slot pair. With a 24-bit sample every word length down to 16 bits is reachable, so sign extension is exercised at each width. Directed framings cover each format, both frame clock styles, both polarities and each pair selection; seeded random configurations that fit within their slots add further combinations.

// File: rtl/sap_pkg.sv
`timescale 1ns/1ps
package sap_pkg;

  localparam int POS_W    = 9;   // bit position in a frame, saturating
  localparam int MAX_WORD = 24;
  localparam int IDX_W    = $clog2(MAX_WORD);

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_TDM = 2'd3
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic       tdmWide;
    logic       pulseSync;
    logic [2:0] frameCode;
    logic [1:0] delayCode;
    logic [1:0] wordCode;
    logic [1:0] txPair;
    logic [1:0] rxPair;
  } sapCfg_t;

  typedef struct packed {
    logic             own;
    logic             hit;
    logic             ch;
    logic [IDX_W-1:0] idx;
    logic             last;
  } slotPos_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             rxShift;
    logic             rxCh;
    logic             rxLast;
    logic             txDrive;
    logic             txLoad;
    logic             txOwn;
    logic             txHit;
    logic             txCh;
    logic [IDX_W-1:0] txIdx;
  } sapStrobe_t;

  function automatic int frameBclks(input logic [2:0] code);
    case (code)
      3'd0:    return 32;
      3'd1:    return 48;
      3'd3:    return 128;
      3'd4:    return 256;
      default: return 64;
    endcase
  endfunction

  function automatic int wordBits(input logic [1:0] code);
    case (code)
      2'd0:    return 24;
      2'd1:    return 20;
      2'd2:    return 18;
      default: return 16;
    endcase
  endfunction

  // where a frame position falls for a given slot pair
  function automatic slotPos_t decodePos(input logic [POS_W-1:0] pos,
                                         input sapCfg_t cfg,
                                         input logic [1:0] pairSel);
    slotPos_t r;
    int ps, lg, slotW, wb, dly, pair, s, st;
    r = '0;
    ps = int'(pos);
    lg = (cfg.fmt != FMT_TDM) ? 1 : (cfg.tdmWide ? 3 : 2);
    slotW = frameBclks(cfg.frameCode) >> lg;
    wb = wordBits(cfg.wordCode);
    case (cfg.fmt)
      FMT_I2S: dly = 1;
      FMT_LJ:  dly = 0;
      FMT_RJ:  dly = slotW - wb;
      default: dly = (cfg.delayCode == 2'd0) ? 0 : ((cfg.delayCode == 2'd1) ? 1 : 8);
    endcase
    if (cfg.fmt != FMT_TDM) pair = 0;
    else if (cfg.tdmWide)   pair = int'(pairSel);
    else                    pair = int'(pairSel[0]);
    for (int c = 0; c < 2; c++) begin
      s = pair * 2 + c;
      if (ps >= s * slotW && ps < (s + 1) * slotW) r.own = 1'b1;
      st = s * slotW + dly;
      if (ps >= st && ps < st + wb) begin
        r.hit  = 1'b1;
        r.ch   = 1'(c);
        r.idx  = IDX_W'(ps - st);
        r.last = (ps - st == wb - 1);
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/sap_ctrl.sv
`timescale 1ns/1ps
module sap_ctrl
  import sap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bclkIn,
  input  logic       lrclkIn,
  input  logic       sdIn,
  input  logic       bclkInv,
  input  logic       lrclkInv,
  input  sapCfg_t    cfg,
  output sapStrobe_t strb,
  output logic       sdBit
);

  localparam int TOP = SYNC_STAGES - 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic [SYNC_STAGES-1:0] bSync, lSync, dSync;
  logic bclkNow, bclkPrev, activeEv, inactEv;
  logic frameLvl, lrLast, frameStart;
  logic [POS_W-1:0] posCnt, posStep;
  slotPos_t rxPos, txPos;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSync <= '0;
      lSync <= '0;
      dSync <= '0;
    end else begin
      bSync <= {bSync[TOP-1:0], bclkIn};
      lSync <= {lSync[TOP-1:0], lrclkIn};
      dSync <= {dSync[TOP-1:0], sdIn};
    end
  end

  assign bclkNow  = bSync[TOP] ^ bclkInv;
  assign activeEv = bclkNow & ~bclkPrev;
  assign inactEv  = ~bclkNow & bclkPrev;
  assign sdBit    = dSync[TOP];

  // I2S with a level frame clock starts on the falling edge
  assign frameLvl   = lSync[TOP] ^ lrclkInv ^ ((cfg.fmt == FMT_I2S) && !cfg.pulseSync);
  assign frameStart = frameLvl & ~lrLast;
  assign posStep    = frameStart ? '0 : ((posCnt == POS_MAX) ? posCnt : posCnt + 1'b1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bclkPrev <= 1'b0;
      lrLast   <= 1'b1;
      posCnt   <= POS_MAX;
    end else begin
      bclkPrev <= bclkNow;
      if (activeEv) begin
        lrLast <= frameLvl;
        posCnt <= posStep;
      end
    end
  end

  assign rxPos = decodePos(posStep, cfg, cfg.rxPair);
  assign txPos = decodePos(posStep, cfg, cfg.txPair);

  always_comb begin
    strb         = '0;
    strb.rxShift = activeEv & rxPos.hit;
    strb.rxCh    = rxPos.ch;
    strb.rxLast  = activeEv & rxPos.hit & rxPos.last;
    strb.txDrive = inactEv;
    strb.txLoad  = inactEv & frameStart;
    strb.txOwn   = txPos.own;
    strb.txHit   = txPos.hit;
    strb.txCh    = txPos.ch;
    strb.txIdx   = txPos.idx;
  end

  // R8: a word bit always lies inside a slot the pair owns
  a_r8_tx_hit_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    (txPos.hit || txPos.last) |-> txPos.own);
  a_r8_rx_hit_in_slot: assert property (@(posedge clk) disable iff (!rstN)
    (rxPos.hit || rxPos.last) |-> rxPos.own);
  // R2: an observed frame edge restarts the position count
  a_r2_pos_restart: assert property (@(posedge clk) disable iff (!rstN)
    (activeEv && frameStart) |=> (posCnt == '0));

endmodule

// File: rtl/sap_datapath.sv
`timescale 1ns/1ps
module sap_datapath
  import sap_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  sapStrobe_t          strb,
  input  logic                sdBit,
  input  logic [1:0]          wordCode,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                sdOut,
  output logic                sdOe,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  localparam int NCH   = 2;
  localparam int BIT_W = $clog2(SAMPLE_W);

  logic [SAMPLE_W-1:0] txIn    [NCH];
  logic [SAMPLE_W-1:0] txWord  [NCH];
  logic [SAMPLE_W-1:0] accNext [NCH];
  logic [SAMPLE_W-1:0] heldLeft, finished, extended, selWord;
  logic [BIT_W-1:0]    bitSel;
  int                  wb;

  assign txIn[0] = txLeft;
  assign txIn[1] = txRight;
  assign wb      = wordBits(wordCode);

  function automatic logic [SAMPLE_W-1:0] signExt(input logic [SAMPLE_W-1:0] v, input int n);
    logic [SAMPLE_W-1:0] r;
    for (int i = 0; i < SAMPLE_W; i++) r[i] = (i < n) ? v[i] : v[n-1];
    return r;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : gLane
    logic [SAMPLE_W-1:0] hold, acc;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        hold <= '0;
        acc  <= '0;
      end else begin
        if (strb.txLoad) hold <= txIn[c];
        if (strb.rxShift && (strb.rxCh == 1'(c))) acc <= accNext[c];
      end
    end
    assign txWord[c]  = strb.txLoad ? txIn[c] : hold;
    assign accNext[c] = {acc[SAMPLE_W-2:0], sdBit};
  end

  // transmit: one bit per inactive edge
  assign selWord = strb.txCh ? txWord[1] : txWord[0];
  assign bitSel  = BIT_W'(wb - 1 - int'(strb.txIdx));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdOe  <= 1'b0;
      sdOut <= 1'b0;
    end else if (strb.txDrive) begin
      sdOe  <= strb.txOwn;
      sdOut <= strb.txOwn & strb.txHit & selWord[bitSel];
    end
  end

  // receive: latch the pair after the right word completes
  assign finished = accNext[strb.rxCh];
  assign extended = signExt(finished, wb);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldLeft <= '0;
      rxLeft   <= '0;
      rxRight  <= '0;
      rxValid  <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.rxLast) begin
        if (!strb.rxCh) heldLeft <= extended;
        else begin
          rxLeft  <= heldLeft;
          rxRight <= extended;
          rxValid <= 1'b1;
        end
      end
    end
  end

  a_r8_idle_line_low: assert property (@(posedge clk) disable iff (!rstN)
    !sdOe |-> !sdOut);
  a_r8_oe_moves_on_edge: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdOe) |-> $past(strb.txDrive));
  a_r11_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);
  a_r11_valid_after_right: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(strb.rxLast && strb.rxCh));
  a_r11_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !rxValid |-> ($stable(rxLeft) && $stable(rxRight)));
  a_r5_sign_ext16: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && wordCode == 2'd3 && $stable(wordCode)) |->
      (rxRight == {{(SAMPLE_W-16){rxRight[15]}}, rxRight[15:0]}));

endmodule

// File: rtl/sap_port.sv
`timescale 1ns/1ps
module sap_port
  import sap_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                bclkIn,
  input  logic                lrclkIn,
  input  logic                sdIn,
  input  logic [1:0]          fmtSel,
  input  logic                tdmWide,
  input  logic                pulseSync,
  input  logic [2:0]          frameCode,
  input  logic [1:0]          delayCode,
  input  logic [1:0]          wordCode,
  input  logic                bclkInv,
  input  logic                lrclkInv,
  input  logic [1:0]          txPairSel,
  input  logic [1:0]          rxPairSel,
  input  logic [SAMPLE_W-1:0] txLeft,
  input  logic [SAMPLE_W-1:0] txRight,
  output logic                sdOut,
  output logic                sdOe,
  output logic [SAMPLE_W-1:0] rxLeft,
  output logic [SAMPLE_W-1:0] rxRight,
  output logic                rxValid
);

  sapCfg_t    cfg;
  sapStrobe_t strb;
  logic       sdBit;

  always_comb begin
    cfg.fmt       = fmt_e'(fmtSel);
    cfg.tdmWide   = tdmWide;
    cfg.pulseSync = pulseSync;
    cfg.frameCode = frameCode;
    cfg.delayCode = delayCode;
    cfg.wordCode  = wordCode;
    cfg.txPair    = txPairSel;
    cfg.rxPair    = rxPairSel;
  end

  sap_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdIn(sdIn),
    .bclkInv(bclkInv), .lrclkInv(lrclkInv), .cfg(cfg), .strb(strb), .sdBit(sdBit)
  );

  sap_datapath #(.SAMPLE_W(SAMPLE_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .sdBit(sdBit), .wordCode(wordCode),
    .txLeft(txLeft), .txRight(txRight), .sdOut(sdOut), .sdOe(sdOe),
    .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

endmodule

// File: tb/sim_sap_port.sv
`timescale 1ns/1ps
module sim_sap_port;

  localparam int W = 24;

  logic clk = 1'b0, rstN = 1'b0;
  logic bclkIn = 1'b0, lrclkIn = 1'b0, sdIn = 1'b0;
  logic [1:0] fmtSel = 2'd0, delayCode = 2'd0, wordCode = 2'd0, txPairSel = 2'd0, rxPairSel = 2'd0;
  logic tdmWide = 1'b0, pulseSync = 1'b0, bclkInv = 1'b0, lrclkInv = 1'b0;
  logic [2:0] frameCode = 3'd2;
  logic [W-1:0] txLeft = '0, txRight = '0;
  logic sdOut, sdOe, rxValid;
  logic [W-1:0] rxLeft, rxRight;

  int checkCnt = 0, failCnt = 0, validCnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sap_port u0 (
    .clk(clk), .rstN(rstN), .bclkIn(bclkIn), .lrclkIn(lrclkIn), .sdIn(sdIn),
    .fmtSel(fmtSel), .tdmWide(tdmWide), .pulseSync(pulseSync), .frameCode(frameCode),
    .delayCode(delayCode), .wordCode(wordCode), .bclkInv(bclkInv), .lrclkInv(lrclkInv),
    .txPairSel(txPairSel), .rxPairSel(rxPairSel), .txLeft(txLeft), .txRight(txRight),
    .sdOut(sdOut), .sdOe(sdOe), .rxLeft(rxLeft), .rxRight(rxRight), .rxValid(rxValid)
  );

  always @(negedge clk) if (rstN && rxValid) validCnt++;

  task automatic check(input bit ok, input string msg);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s", msg);
    end
  endtask

  // ---- model of the framing, from the requirements ----
  function automatic int nBits();  // R12
    case (frameCode)
      3'd0: return 32; 3'd1: return 48; 3'd3: return 128; 3'd4: return 256;
      default: return 64;
    endcase
  endfunction
  function automatic int wLen();   // R5
    return (wordCode == 0) ? 24 : (wordCode == 1) ? 20 : (wordCode == 2) ? 18 : 16;
  endfunction
  function automatic int slots();
    return (fmtSel != 3) ? 2 : (tdmWide ? 8 : 4);
  endfunction
  function automatic int slotW();
    return nBits() / slots();
  endfunction
  function automatic int msbOfs();  // R2 R3 R4 R6
    if (fmtSel == 0) return 1;
    if (fmtSel == 1) return 0;
    if (fmtSel == 2) return slotW() - wLen();
    return (delayCode == 0) ? 0 : (delayCode == 1) ? 1 : 8;
  endfunction
  function automatic int pairOf(input logic [1:0] p);  // R7
    if (fmtSel != 3) return 0;
    return tdmWide ? int'(p) : int'(p[0]);
  endfunction
  function automatic bit fits();
    return (msbOfs() >= 0) && (msbOfs() + wLen() <= slotW());
  endfunction
  function automatic logic lrLevel(input int b);  // R2 R9 R10
    logic v;
    if (pulseSync) v = (b == 0);
    else begin
      v = (b < nBits() / 2);
      if (fmtSel == 0) v = ~v;
    end
    return v ^ lrclkInv;
  endfunction
  // bit for position b of the word pair; oe says the slot belongs to the pair
  function automatic logic [1:0] lineBit(input int b, input int pair,
                                         input logic [31:0] l, input logic [31:0] r);
    logic oe = 0, d = 0;
    for (int c = 0; c < 2; c++) begin
      int s0 = (pair * 2 + c) * slotW();
      int k  = b - s0 - msbOfs();
      logic [31:0] w = (c == 0) ? l : r;
      if (b >= s0 && b < s0 + slotW()) oe = 1;
      if (k >= 0 && k < wLen()) d = w[wLen() - 1 - k];
    end
    return {oe, d};
  endfunction
  function automatic logic [W-1:0] sx(input logic [31:0] v);  // R5
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i < wLen()) ? v[i] : v[wLen() - 1];
    return r;
  endfunction

  task automatic playFrame(input bit doCheck, input string req);
    logic [W-1:0] eL, eR;
    logic [31:0] sL, sR;
    logic [1:0] ex, rb;
    int vBase, txErr, badB;
    logic [1:0] badAct, badExp;
    eL = txLeft; eR = txRight;
    sL = $urandom; sR = $urandom;
    vBase = validCnt; txErr = 0; badB = 0; badAct = 0; badExp = 0;
    for (int b = 0; b < nBits(); b++) begin
      bclkIn  = bclkInv;           // inactive edge
      lrclkIn = lrLevel(b);
      rb = lineBit(b, pairOf(rxPairSel), sL, sR);
      sdIn = (rb[1] && (b - (b / slotW()) * slotW() - msbOfs()) >= 0) ? rb[0] : 1'($urandom);
      if (rb[1]) sdIn = rb[0];
      if (!rb[1]) sdIn = 1'($urandom);
      if (b == 1) begin txLeft = W'($urandom); txRight = W'($urandom); end
      #70;
      ex = lineBit(b, pairOf(txPairSel), {8'd0, eL}, {8'd0, eR});
      if ({sdOe, sdOut} !== ex) begin
        if (txErr == 0) begin badB = b; badAct = {sdOe, sdOut}; badExp = ex; end
        txErr++;
      end
      #10;
      bclkIn = ~bclkInv;           // active edge
      #80;
    end
    if (doCheck) begin
      check(txErr == 0, $sformatf("%s R8 R13 tx bit %0d {oe,data}: got %b expected %b",
                                  req, badB, badAct, badExp));
      check(rxLeft == sx(sL) && rxRight == sx(sR),
            $sformatf("%s R5 rx pair: got %h/%h expected %h/%h",
                      req, rxLeft, rxRight, sx(sL), sx(sR)));
      check(validCnt - vBase == 1, $sformatf("%s R11 rxValid pulses: got %0d expected 1",
                                             req, validCnt - vBase));
    end
  endtask

  task automatic runCfg(input string req);
    playFrame(0, req);
    playFrame(1, req);
    playFrame(1, req);
  endtask

  task automatic setCfg(input int f, input bit wide, input bit pulse, input int fc,
                        input int dc, input int wc, input int tp, input int rp,
                        input bit bi, input bit li);
    fmtSel = 2'(f); tdmWide = wide; pulseSync = pulse; frameCode = 3'(fc);
    delayCode = 2'(dc); wordCode = 2'(wc); txPairSel = 2'(tp); rxPairSel = 2'(rp);
    bclkInv = bi; lrclkInv = li;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sdOe == 0 && sdOut == 0, $sformatf("R1 line in reset: got %b%b expected 00", sdOe, sdOut));
    check(rxValid == 0, $sformatf("R1 rxValid in reset: got %b expected 0", rxValid));
    check(rxLeft == 0 && rxRight == 0,
          $sformatf("R1 rx words in reset: got %h/%h expected 0/0", rxLeft, rxRight));
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #5;
    txLeft = W'($urandom); txRight = W'($urandom);

    setCfg(0, 0, 0, 2, 0, 0, 0, 0, 0, 0); runCfg("R2 i2s64w24");
    setCfg(1, 0, 0, 2, 0, 3, 0, 0, 0, 0); runCfg("R3 lj64w16");
    setCfg(2, 0, 0, 2, 0, 0, 0, 0, 0, 0); runCfg("R4 rj64w24");
    setCfg(2, 0, 0, 2, 0, 1, 0, 0, 0, 0); runCfg("R4 rj64w20");
    setCfg(2, 0, 0, 1, 0, 2, 0, 0, 0, 0); runCfg("R4 rj48w18");
    setCfg(3, 0, 0, 3, 1, 0, 1, 0, 0, 0); runCfg("R6 tdm4 d1 tx1 rx0");
    setCfg(3, 1, 0, 4, 2, 0, 3, 2, 0, 0); runCfg("R6 tdm8 d8 tx3 rx2");
    setCfg(3, 0, 0, 4, 0, 1, 2, 3, 0, 0); runCfg("R7 tdm4 pair bit1 ignored");
    setCfg(1, 0, 1, 2, 0, 0, 0, 0, 0, 0); runCfg("R9 pulse lj");
    setCfg(3, 1, 1, 4, 1, 3, 1, 3, 0, 0); runCfg("R9 pulse tdm8");
    setCfg(0, 0, 0, 2, 0, 2, 0, 0, 1, 1); runCfg("R10 i2s both inverted");
    setCfg(1, 0, 0, 2, 0, 0, 0, 0, 1, 0); runCfg("R10 lj bclk inverted");
    setCfg(1, 0, 0, 1, 0, 0, 0, 0, 0, 0); runCfg("R12 lj48");
    setCfg(1, 0, 0, 6, 0, 1, 0, 0, 0, 0); runCfg("R12 code6 is 64");

    for (int n = 0; n < 8; n++) begin
      do begin
        setCfg(int'($urandom_range(3)), 1'($urandom), 1'($urandom), int'($urandom_range(7)),
               int'($urandom_range(2)), int'($urandom_range(3)), int'($urandom_range(3)),
               int'($urandom_range(3)), 1'($urandom), 1'($urandom));
      end while (!fits());
      runCfg($sformatf("R6 R7 random%0d", n));
    end

    done = 1;
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
      $finish;
    end
  end

endmodule